// File: doc/BRIEF.md
# Flash Thermometer-to-Binary Encoder

This block is the digital back end of a 6-bit flash converter. It receives the 63 comparator outputs as a thermometer word and returns the number of comparators that are set, as a 6-bit binary code. The result appears on the output a fixed two clock cycles after the thermometer word is sampled.

The incoming word first goes through a three-input majority vote on each line, which removes an isolated wrong comparator. The cleaned word is then reduced to a single marker line at the top of the run of ones. The 64 possible marker positions are split into four groups of sixteen. Each group has a small ROM encoder that returns a 4-bit position within the group and a hit bit. A selection stage turns the four hit bits into the two upper code bits. Two register stages retime the result: the group results are registered first, then the final code.

Top module: `flash_therm_encoder`

## Requirements
- R1: Comparator line k (k = 1..63) is carried on `therm_i[k-1]`. Line 0 is taken as always set and line 64 as always clear. A clean level N (lines 1..N set, all others clear, N = 0..63) yields `code_o` = N.
- R2: The latency is exactly two clock cycles. A word driven before rising edge e appears on `code_o` after edge e+1. After edge e, `code_o` still shows the previous result.
- R3: A single line j cleared inside a clean level N, with 1 ≤ j ≤ N-2, has no effect. `code_o` is still N.
- R4: A single line j set above a clean level N, with N+3 ≤ j ≤ 63, has no effect. `code_o` is still N.
- R5: Marker positions are grouped as 0..15, 16..31, 32..47 and 48..63 (groups 0 to 3). `code_o[5:4]` is the lowest-numbered group that holds a marker, and at least one group always holds one.
- R6: `code_o[3:0]` is the bitwise OR of the in-group positions (marker position mod 16) of every group that holds a marker.
- R7: A synchronous active-high `rst_i` clears both register stages. `code_o` is 0 after any edge with reset high and also after the first edge following release. The new input appears after the second edge following release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| therm_i | input | 63 | Comparator outputs; bit k-1 carries line k |
| code_o | output | 6 | Registered binary code |

## Verification
Two functions can act on the same word in one cycle: bubble removal and group selection. A lone cleared line at line 16 sits on the boundary between groups 0 and 1. If it leaks through the vote, it creates a second marker in a different group. The bench drives this case and expects the true level, not a group-0 code.

Reset and pipeline advance can also collide. The bench asserts reset one cycle after a fresh level enters. It expects zero for two samples, then the level present at release.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

    localparam int LINES      = 63;
    localparam int HOT_W      = LINES + 1;
    localparam int CODE_W     = $clog2(HOT_W);
    localparam int GROUP_W    = 16;
    localparam int NUM_GROUPS = HOT_W / GROUP_W;
    localparam int LOW_W      = $clog2(GROUP_W);
    localparam int HIGH_W     = $clog2(NUM_GROUPS);

    typedef struct packed {
        logic             hit;
        logic [LOW_W-1:0] low;
    } group_code_t;

    typedef logic [CODE_W-1:0] code_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // OR of the indices of all set lines; exact for a one-hot slice
    function automatic logic [LOW_W-1:0] slice_index(input logic [GROUP_W-1:0] s);
        logic [LOW_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            if (s[i]) idx = idx | LOW_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/therm_bubble_filter.sv
module therm_bubble_filter
    import therm_enc_pkg::*;
(
    input  logic [LINES-1:0] therm_i,
    output logic [HOT_W-1:0] hot_o
);
    // ext[0] forced high, ext[LINES+1] forced low
    logic [LINES+1:0] ext;
    logic [LINES+1:0] clean;

    assign ext = {1'b0, therm_i, 1'b1};

    assign clean[0]       = 1'b1;
    assign clean[LINES+1] = 1'b0;

    generate
        for (genvar k = 1; k <= LINES; k++) begin : g_vote
            assign clean[k] = maj3(ext[k-1], ext[k], ext[k+1]);
        end
        for (genvar k = 0; k < HOT_W; k++) begin : g_edge
            assign hot_o[k] = clean[k] & ~clean[k+1];
        end
    endgenerate

endmodule

// File: rtl/therm_group_rom.sv
module therm_group_rom
    import therm_enc_pkg::*;
(
    input  logic [GROUP_W-1:0] slice_i,
    output group_code_t        grp_o
);
    always_comb begin
        grp_o.hit = |slice_i;
        grp_o.low = slice_index(slice_i);
    end
endmodule

// File: rtl/therm_group_select.sv
module therm_group_select
    import therm_enc_pkg::*;
(
    input  group_code_t [NUM_GROUPS-1:0] grp_i,
    output code_t                        code_o
);
    logic [HIGH_W-1:0] high;
    logic [LOW_W-1:0]  low;

    always_comb begin
        high = '0;
        low  = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_i[g].hit) high = HIGH_W'(g);
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_i[g].hit) low = low | grp_i[g].low;
        end
        code_o = {high, low};
    end
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
    import therm_enc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LINES-1:0] therm_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HOT_W-1:0]               hot;
    group_code_t [NUM_GROUPS-1:0]   grp_d;
    group_code_t [NUM_GROUPS-1:0]   grp_q;
    logic [NUM_GROUPS-1:0]          s1_valid;
    code_t                          code_d;

    therm_bubble_filter u_filter (
        .therm_i (therm_i),
        .hot_o   (hot)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rom
            therm_group_rom u_rom (
                .slice_i (hot[g*GROUP_W +: GROUP_W]),
                .grp_o   (grp_d[g])
            );
            assign s1_valid[g] = grp_q[g].hit;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) grp_q <= '0;
        else       grp_q <= grp_d;
    end

    therm_group_select u_sel (
        .grp_i  (grp_q),
        .code_o (code_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) code_o <= '0;
        else       code_o <= code_d;
    end

endmodule

// File: rtl/therm_enc_checker.sv
module therm_enc_checker
    import therm_enc_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_i,
    input logic [LINES-1:0]      therm_i,
    input logic [CODE_W-1:0]     code_o,
    input logic [NUM_GROUPS-1:0] s1_valid
);
    logic [1:0] age = 2'd0;

    always_ff @(posedge clk_i) begin
        if (age != 2'd3) age <= age + 2'd1;
    end

    function automatic logic is_clean(input logic [LINES-1:0] v);
        logic [LINES:0] w;
        w = {1'b0, v};
        return ((w + 1'b1) & w) == '0;
    endfunction

    // R1 / R2: clean level seen two edges earlier comes out as its count
    assert_clean_level_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (age >= 2'd2 && !$past(rst_i) && !$past(rst_i, 2) && is_clean($past(therm_i, 2)))
        |-> code_o == CODE_W'($countones($past(therm_i, 2))));

    // R7: output cleared by reset
    assert_reset_out_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (age >= 2'd1 && $past(rst_i)) |-> code_o == '0);

    // R7: first stage cleared as well
    assert_reset_stage_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (age >= 2'd2 && $past(rst_i, 2) && !$past(rst_i)) |-> code_o == '0);

    // R5: some group always holds a marker
    assert_group_hit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (age >= 2'd1 && !$past(rst_i)) |-> s1_valid != '0);

endmodule

bind flash_therm_encoder therm_enc_checker u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .therm_i  (therm_i),
    .code_o   (code_o),
    .s1_valid (s1_valid)
);

// File: tb/flash_therm_encoder_tb.sv
module flash_therm_encoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [62:0] therm = '0;
    logic [5:0]  code;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flash_therm_encoder u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .therm_i (therm),
        .code_o  (code)
    );

    function automatic logic [62:0] level(input int n);
        logic [63:0] w;
        w = (64'd1 << n) - 64'd1;
        return w[62:0];
    endfunction

    function automatic logic [62:0] lines(input int a, input int b);
        logic [62:0] v;
        v = '0;
        for (int k = a; k <= b; k++) v[k-1] = 1'b1;
        return v;
    endfunction

    task automatic check(input logic [5:0] exp, input string req);
        checks++;
        if (code !== exp) begin
            errors++;
            $display("FAIL %s: code_o actual %0d expected %0d", req, code, exp);
        end
    endtask

    task automatic run_vec(input logic [62:0] v, input logic [5:0] exp, input string req);
        @(negedge clk) therm = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        therm = level(33);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(6'd0, "R7");
        rst = 1'b0;
    endtask

    task automatic t_sweep;
        for (int n = 0; n <= 63; n++) run_vec(level(n), 6'(n), "R1");
    endtask

    task automatic t_latency;
        run_vec(level(10), 6'd10, "R2");
        @(negedge clk) therm = level(50);
        @(posedge clk);
        @(negedge clk) check(6'd10, "R2");
        @(posedge clk);
        @(negedge clk) check(6'd50, "R2");
    endtask

    task automatic t_bubble_low;
        int ns[3] = '{20, 40, 63};
        for (int i = 0; i < 3; i++) begin
            int js[3];
            js[0] = 1; js[1] = ns[i] / 2; js[2] = ns[i] - 2;
            for (int m = 0; m < 3; m++) begin
                logic [62:0] v;
                v = level(ns[i]);
                v[js[m]-1] = 1'b0;
                run_vec(v, 6'(ns[i]), "R3");
            end
        end
        // cleared line on the group 0/1 boundary
        begin
            logic [62:0] v;
            v = level(40);
            v[15] = 1'b0;
            run_vec(v, 6'd40, "R3");
        end
    endtask

    task automatic t_bubble_high;
        int ns[3] = '{0, 10, 30};
        for (int i = 0; i < 3; i++) begin
            int js[3];
            js[0] = ns[i] + 3; js[1] = 50; js[2] = 63;
            for (int m = 0; m < 3; m++) begin
                logic [62:0] v;
                v = level(ns[i]);
                v[js[m]-1] = 1'b1;
                run_vec(v, 6'(ns[i]), "R4");
            end
        end
    endtask

    task automatic t_multi;
        // markers at 20 (group 1, low 4) and 47 (group 2, low 15)
        run_vec(lines(1, 20) | lines(41, 47), 6'd31, "R5");
        // markers at 5 and 37: both low 5
        run_vec(lines(1, 5) | lines(21, 37), 6'd5, "R6");
        // markers at 3 and 44: low 3 | 12
        run_vec(lines(1, 3) | lines(41, 44), 6'd15, "R6");
    endtask

    task automatic t_reset_mid;
        run_vec(level(40), 6'd40, "R7");
        @(negedge clk) begin rst = 1'b1; therm = level(12); end
        @(posedge clk);
        @(negedge clk) check(6'd0, "R7");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk) check(6'd0, "R7");
        @(posedge clk);
        @(negedge clk) check(6'd12, "R7");
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_latency();
        t_bubble_low();
        t_bubble_high();
        t_multi();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule